// File: doc/BRIEF.md
# Flash Erase Range Planner

The planner turns a request to erase a run of consecutive 4 KB flash sectors into the shortest sequence of erase commands that a greedy choice can give. A request carries the index of the first sector and the number of sectors. At each step the planner looks at the current sector index and the number of sectors still to erase. It then emits one command: a 64 KB block erase, a 32 KB block erase or a single-sector erase. Each command carries an 8-bit opcode and a byte address, and goes to a downstream flash command engine.

Both the request input and the command output are valid/ready streams. A request is taken only while the planner is idle (`req_ready` high), and only when `req_valid` and `req_ready` are both high at a clock edge. A command is presented with `cmd_valid` and stays unchanged until the consumer raises `cmd_ready`. The consumer may hold `cmd_ready` low for any number of cycles. Nothing advances while the command waits. When the range is covered, the planner pulses `done` for one cycle and gives the original sector count on `done_count`. The planner is then idle again. Issuing the bus transaction and checking write protection are the job of the command engine.

Top module: `erase_range_planner`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0 and `done` is 0.
- R2: When the current sector index is a multiple of 16 and at least 16 sectors remain, the command opcode is 0xD8 and the planner then advances by 16 sectors.
- R3: When R2 does not apply, the index is a multiple of 8 and at least 8 sectors remain, the opcode is 0x52 and the planner advances by 8.
- R4: In every other case the opcode is 0x20 and the planner advances by 1 sector.
- R5: The command byte address equals the current sector index shifted left by 12 (bits [11:0] are zero).
- R6: While `cmd_valid` is 1 and `cmd_ready` is 0, opcode and address hold their values and `cmd_valid` stays 1. The next step is computed only after acceptance.
- R7: `req_ready` is 0 from the cycle after a request is accepted until the planner is idle again. A request offered in that time is ignored and does not change the commands.
- R8: `done` is 1 for exactly one cycle, in the cycle after the final command is accepted. During that cycle `done_count` equals the requested sector count.
- R9: A request with a count of 0 emits no command, and `done` rises in the cycle after that request is accepted.
- R10: The accepted commands cover the requested range exactly. They go in ascending address order with no gap or overlap, and the sizes add up to the count.
- R11: `req_ready` is 1 again in the cycle after `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Erase request offered |
| req_ready | output | 1 | Planner idle and able to take a request |
| req_first | input | SECT_W | Index of the first 4 KB sector |
| req_count | input | SECT_W+1 | Number of sectors to erase |
| cmd_valid | output | 1 | Erase command presented |
| cmd_ready | input | 1 | Consumer takes the command |
| cmd_opcode | output | 8 | Erase opcode (0xD8, 0x52 or 0x20) |
| cmd_addr | output | SECT_W+12 | Byte address of the erase unit |
| done | output | 1 | One-cycle pulse when the range is covered |
| done_count | output | SECT_W+1 | Original sector count, valid with done |

## Verification
The bench sweeps every start index and count in a small window, both with a consumer that is always ready and with one that stalls at pseudo-random times. This targets the boundaries where the unit choice changes: an index just off a multiple of 8 or 16, and a remainder one sector short of a block. A planner that got a compare off by one would issue a block erase that runs past the range, or would split an aligned block into sectors. Stalls show whether a design advances on `cmd_valid` alone, which would skip or repeat units. Directed cases check three things. First, a zero count must finish without any command. Second, a request held on the input while busy must be ignored. Third, the full device range and the top 64 KB block must not wrap the address or lose the count.

// File: rtl/erp_pkg.sv
package erp_pkg;

  localparam int unsigned ERP_SECTOR_SHIFT = 12;
  localparam int unsigned ERP_TIERS        = 3;

  localparam logic [7:0] OPC_BLK64 = 8'hD8;
  localparam logic [7:0] OPC_BLK32 = 8'h52;
  localparam logic [7:0] OPC_SECT  = 8'h20;

  // Erase tiers, highest priority at index 0: log2 of size in sectors, opcode
  localparam int unsigned TIER_LOG2 [ERP_TIERS] = '{4, 3, 0};
  localparam logic [7:0]  TIER_OPC  [ERP_TIERS] = '{OPC_BLK64, OPC_BLK32, OPC_SECT};

  typedef enum logic [1:0] {
    PL_IDLE = 2'd0,
    PL_EMIT = 2'd1,
    PL_DONE = 2'd2
  } pl_state_e;

endpackage

// File: rtl/erp_unit_select.sv
module erp_unit_select
  import erp_pkg::*;
#(
  parameter int SECT_W = 14,
  parameter int CNT_W  = SECT_W + 1
) (
  input  logic [SECT_W-1:0] cur,
  input  logic [CNT_W-1:0]  rem,
  output logic [7:0]        opcode,
  output logic [CNT_W-1:0]  step
);

  logic [ERP_TIERS-1:0] unit_fits;
  logic [CNT_W-1:0]     unit_size [ERP_TIERS];

  for (genvar g = 0; g < ERP_TIERS; g++) begin : g_tier
    localparam int unsigned LG = TIER_LOG2[g];
    localparam logic [CNT_W-1:0]  SZ  = CNT_W'(64'd1 << LG);
    localparam logic [SECT_W-1:0] MSK = SECT_W'((64'd1 << LG) - 64'd1);
    assign unit_fits[g] = ((cur & MSK) == '0) && (rem >= SZ);
    assign unit_size[g] = SZ;
  end

  // Walk from lowest to highest priority so the largest fitting unit wins
  always_comb begin
    opcode = TIER_OPC[ERP_TIERS-1];
    step   = unit_size[ERP_TIERS-1];
    for (int i = ERP_TIERS - 1; i >= 0; i--) begin
      if (unit_fits[i]) begin
        opcode = TIER_OPC[i];
        step   = unit_size[i];
      end
    end
  end

endmodule

// File: rtl/erp_cursor.sv
module erp_cursor #(
  parameter int SECT_W = 14,
  parameter int CNT_W  = SECT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              adv,
  input  logic [SECT_W-1:0] load_first,
  input  logic [CNT_W-1:0]  load_count,
  input  logic [CNT_W-1:0]  step,
  output logic [SECT_W-1:0] cur,
  output logic [CNT_W-1:0]  rem,
  output logic [CNT_W-1:0]  total
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur   <= '0;
      rem   <= '0;
      total <= '0;
    end else if (load) begin
      cur   <= load_first;
      rem   <= load_count;
      total <= load_count;
    end else if (adv) begin
      cur <= cur + step[SECT_W-1:0];
      rem <= rem - step;
    end
  end

endmodule

// File: rtl/erp_ctrl.sv
module erp_ctrl
  import erp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic count_zero,
  input  logic cmd_ready,
  input  logic last_step,
  output logic req_ready,
  output logic cmd_valid,
  output logic done,
  output logic load,
  output logic adv
);

  pl_state_e state, state_nx;

  assign req_ready = (state == PL_IDLE);
  assign cmd_valid = (state == PL_EMIT);
  assign done      = (state == PL_DONE);
  assign load      = req_ready & req_valid;
  assign adv       = cmd_valid & cmd_ready;

  always_comb begin
    state_nx = state;
    unique case (state)
      PL_IDLE: if (req_valid) state_nx = count_zero ? PL_DONE : PL_EMIT;
      PL_EMIT: if (cmd_ready && last_step) state_nx = PL_DONE;
      PL_DONE: state_nx = PL_IDLE;
      default: state_nx = PL_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= PL_IDLE;
    else        state <= state_nx;
  end

endmodule

// File: rtl/erase_range_planner.sv
module erase_range_planner
  import erp_pkg::*;
#(
  parameter  int SECT_W = 14,
  localparam int CNT_W  = SECT_W + 1,
  localparam int ADDR_W = SECT_W + ERP_SECTOR_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [SECT_W-1:0] req_first,
  input  logic [CNT_W-1:0]  req_count,
  output logic              cmd_valid,
  input  logic              cmd_ready,
  output logic [7:0]        cmd_opcode,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic              done,
  output logic [CNT_W-1:0]  done_count
);

  logic [SECT_W-1:0] cur;
  logic [CNT_W-1:0]  rem;
  logic [CNT_W-1:0]  step;
  logic              load;
  logic              adv;

  erp_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .count_zero (req_count == '0),
    .cmd_ready  (cmd_ready),
    .last_step  (rem == step),
    .req_ready  (req_ready),
    .cmd_valid  (cmd_valid),
    .done       (done),
    .load       (load),
    .adv        (adv)
  );

  erp_cursor #(.SECT_W(SECT_W), .CNT_W(CNT_W)) u_cursor (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (load),
    .adv        (adv),
    .load_first (req_first),
    .load_count (req_count),
    .step       (step),
    .cur        (cur),
    .rem        (rem),
    .total      (done_count)
  );

  erp_unit_select #(.SECT_W(SECT_W), .CNT_W(CNT_W)) u_select (
    .cur    (cur),
    .rem    (rem),
    .opcode (cmd_opcode),
    .step   (step)
  );

  assign cmd_addr = ADDR_W'(cur) << ERP_SECTOR_SHIFT;

endmodule

// File: rtl/erp_checker.sv
module erp_checker
  import erp_pkg::*;
#(
  parameter  int SECT_W = 14,
  localparam int CNT_W  = SECT_W + 1,
  localparam int ADDR_W = SECT_W + ERP_SECTOR_SHIFT
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [SECT_W-1:0] req_first,
  input logic [CNT_W-1:0]  req_count,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic [7:0]        cmd_opcode,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              done,
  input logic [CNT_W-1:0]  done_count
);

  logic [CNT_W:0]    covered;
  logic [ADDR_W-1:0] next_addr;
  logic              have_prev;
  logic [CNT_W:0]    unit_sz;

  always_comb begin
    if (cmd_opcode == OPC_BLK64)      unit_sz = (CNT_W+1)'(16);
    else if (cmd_opcode == OPC_BLK32) unit_sz = (CNT_W+1)'(8);
    else                              unit_sz = (CNT_W+1)'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      covered   <= '0;
      next_addr <= '0;
      have_prev <= 1'b0;
    end else if (req_valid && req_ready) begin
      covered   <= '0;
      have_prev <= 1'b0;
    end else if (cmd_valid && cmd_ready) begin
      covered   <= covered + unit_sz;
      next_addr <= cmd_addr + (ADDR_W'(unit_sz) << ERP_SECTOR_SHIFT);
      have_prev <= 1'b1;
    end
  end

  // R6
  cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_opcode) && $stable(cmd_addr));

  // R7
  busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && (cmd_valid || done)));

  // R2
  blk64_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_opcode == OPC_BLK64 |-> cmd_addr[15:0] == '0);

  // R3
  blk32_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_opcode == OPC_BLK32 |-> cmd_addr[14:0] == '0);

  // R5
  addr_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> cmd_addr[ERP_SECTOR_SHIFT-1:0] == '0);

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R11
  ready_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);

  // R9
  zero_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_count == '0 |=> done);

  // R10
  contiguous_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && have_prev |-> cmd_addr == next_addr);

  // R10
  coverage_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> covered == {1'b0, done_count});

endmodule

bind erase_range_planner erp_checker #(.SECT_W(SECT_W)) u_erp_checker (.*);

// File: tb/tb_erase_range_planner.sv
module tb_erase_range_planner;

  localparam int SECT_W = 14;
  localparam int CNT_W  = SECT_W + 1;
  localparam int ADDR_W = SECT_W + 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [SECT_W-1:0] req_first = '0;
  logic [CNT_W-1:0]  req_count = '0;
  logic              cmd_valid;
  logic              cmd_ready = 1'b0;
  logic [7:0]        cmd_opcode;
  logic [ADDR_W-1:0] cmd_addr;
  logic              done;
  logic [CNT_W-1:0]  done_count;

  int   n_chk  = 0;
  int   n_fail = 0;
  bit   finished = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  always #4 clk = ~clk;

  erase_range_planner #(.SECT_W(SECT_W)) dut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Greedy expectation from the unit rules
  task automatic exp_pick(input int cur, input int rem, output int opc, output int step);
    if (cur % 16 == 0 && rem >= 16)     begin opc = 8'hD8; step = 16; end
    else if (cur % 8 == 0 && rem >= 8)  begin opc = 8'h52; step = 8;  end
    else                                begin opc = 8'h20; step = 1;  end
  endtask

  // mode 0: always ready, 1: stalling consumer, 2: stalling plus a junk request held while busy
  task automatic run_req(input int s, input int c, input int mode);
    int  cur, rem, eo, es;
    bit  rdy, stalled;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_first = SECT_W'(s);
    req_count = CNT_W'(c);
    @(negedge clk);
    if (mode == 2) begin
      req_first = ~SECT_W'(s);
      req_count = CNT_W'(7);
    end else begin
      req_valid = 1'b0;
    end
    cur = s;
    rem = c;
    stalled = 1'b0;
    forever begin
      if (done) begin
        req_valid = 1'b0;
        chk(rem == 0, "R10", "sectors left at done", rem, 0);
        chk(done_count == CNT_W'(c), (c == 0) ? "R9" : "R8", "done_count", done_count, c);
        break;
      end
      if (!cmd_valid) begin
        req_valid = 1'b0;
        chk(1'b0, (rem == 0) ? "R8" : "R10", "neither command nor done", 0, 1);
        break;
      end
      chk(!req_ready, "R7", "req_ready while busy", req_ready, 0);
      chk(rem != 0, (c == 0) ? "R9" : "R10", "extra command", rem, 1);
      exp_pick(cur, rem, eo, es);
      chk(cmd_opcode == 8'(eo),
          stalled ? "R6" : (es == 16) ? "R2" : (es == 8) ? "R3" : "R4",
          "opcode", cmd_opcode, eo);
      chk(cmd_addr == (ADDR_W'(cur) << 12), stalled ? "R6" : "R5", "address",
          cmd_addr, longint'(cur) << 12);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rdy  = (mode == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
      cmd_ready = rdy;
      @(negedge clk);
      if (rdy) begin
        cur = cur + es;
        rem = rem - es;
      end
      stalled = !rdy;
    end
    cmd_ready = 1'b0;
    @(negedge clk);
    chk(req_ready, "R11", "req_ready after done", req_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R10 watchdog: actual hang expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(req_ready == 1'b1, "R1", "req_ready in reset", req_ready, 1);
    chk(cmd_valid == 1'b0, "R1", "cmd_valid in reset", cmd_valid, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && !cmd_valid && !done, "R1", "idle after reset",
        {req_ready, cmd_valid, done}, 3'b100);

    // R9 zero count
    run_req(5, 0, 0);
    // R2 top aligned block of the device
    run_req(16368, 16, 1);
    // R7 junk request held while busy
    run_req(3, 40, 2);

    // Sweep of start and count, both consumer behaviours (R2, R3, R4, R6, R10)
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 36; s++)
        for (int c = 0; c < 36; c++)
          run_req(s, c, m);

    // Whole device (R8, R10)
    run_req(0, 16384, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule